// File: doc/BRIEF.md
# Triggered Pattern Output Staging Register

This block stages the next 8-bit value for two 4-bit pattern output groups and moves it into the port output data register when a timer compare-match strobe arrives. The upper nibble of the staged value belongs to the high group and the lower nibble to the low group. Software writes the next pattern through a small register interface ahead of time. The copy into the port data register then happens on the strobe, so the output pattern changes at a time set by the timer and not by the bus.

A mode input selects one of two cases. In the shared case, both groups follow the low group's strobe, and one address holds the whole byte. In the separate case, each group follows its own strobe, and each nibble has its own address. Each group also has a pattern-output enable. A cleared enable freezes that group's port bits.

A hardware standby input clears the staged value. A software standby input models a stopped clock: while it is high, all stored state holds.

Top module: `pattern_stage`

## Requirements
- R1: After the asynchronous active-low reset, the staging register and port_q are both 0x00.
- R2: With mode_split=0, a write to offset 4 stores all 8 bits of bus_wdata, and a read at offset 4 returns the full staged byte.
- R3: With mode_split=0, a read at offset 6 returns 0xFF, and a write to offset 6 leaves the staged byte unchanged.
- R4: With mode_split=1, offset 4 holds the high nibble (bits 7:4, read with bits 3:0 as ones) and offset 6 holds the low nibble (bits 3:0, read with bits 7:4 as ones). A write to one offset leaves the other nibble unchanged.
- R5: With mode_split=1, a trig_hi pulse copies only staged bits 7:4 into port_q[7:4], and a trig_lo pulse copies only bits 3:0 into port_q[3:0]. port_q updates at the clock edge that samples the strobe.
- R6: With mode_split=0, a trig_lo pulse copies both nibbles, each gated by its own group enable, and trig_hi has no effect.
- R7: While a group's enable (en_hi for bits 7:4, en_lo for bits 3:0) is low, that group's port_q bits keep their value when a strobe arrives.
- R8: When a bus write and a strobe occur in the same cycle, port_q receives the staged value from before the write, and the write still takes effect.
- R9: A cycle with hw_standby high clears the staging register to 0x00 and leaves port_q unchanged.
- R10: While sw_standby is high, bus writes and strobes are ignored, and both the staging register and port_q hold their values.
- R11: Offsets other than 4 and 6 read as 0xFF, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_standby | input | 1 | Hardware standby; clears the staging register |
| sw_standby | input | 1 | Software standby; freezes all stored state |
| mode_split | input | 1 | 1 = separate strobe per group, 0 = shared strobe |
| bus_addr | input | 3 | Register offset within the window |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational from address) |
| trig_hi | input | 1 | Compare-match strobe for the high group |
| trig_lo | input | 1 | Compare-match strobe for the low group |
| en_hi | input | 1 | Pattern output enable for the high group |
| en_lo | input | 1 | Pattern output enable for the low group |
| port_q | output | 8 | Port output data register |

## Verification
The hardest case to reach is a bus write and a strobe that land in the same clock edge. There, the port must capture the old staged byte while the register takes the new one. The bench drives bus_we and trig_lo high in the same low clock phase. It then checks port_q against the old value and reads back the new value. A second strobe afterwards confirms that the new value does reach the port. Standby freezing is checked by issuing a write and a strobe during sw_standby, then checking both the port and the readback once standby ends.

// File: rtl/pstage_pkg.sv
package pstage_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_BASE = 2'd1,
    SEL_ALT  = 2'd2
  } sel_e;
endpackage

// File: rtl/pstage_regfile.sv
module pstage_regfile
  import pstage_pkg::*;
#(
  parameter int GRP_W    = 4,
  parameter int ADDR_W   = 3,
  parameter int BASE_OFF = 4,
  parameter int ALT_OFF  = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hw_standby,
  input  logic                 sw_standby,
  input  logic                 mode_split,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 we,
  input  logic [2*GRP_W-1:0]   wdata,
  output logic [2*GRP_W-1:0]   stage,
  output logic [2*GRP_W-1:0]   rdata
);
  localparam int DW = 2 * GRP_W;
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE_OFF);
  localparam logic [ADDR_W-1:0] ALT_A  = ADDR_W'(ALT_OFF);
  localparam logic [GRP_W-1:0]  ONES_N = '1;

  sel_e             sel;
  logic             wr_hi, wr_lo, stage_en;
  logic [DW-1:0]    stage_d, stage_q;

  always_comb begin
    if (addr == BASE_A)     sel = SEL_BASE;
    else if (addr == ALT_A) sel = SEL_ALT;
    else                    sel = SEL_NONE;
  end

  always_comb begin
    wr_hi = 1'b0;
    wr_lo = 1'b0;
    case (sel)
      SEL_BASE: begin
        wr_hi = 1'b1;
        wr_lo = !mode_split;
      end
      SEL_ALT:  wr_lo = mode_split;
      default:  ;
    endcase
  end

  always_comb begin
    stage_d = stage_q;
    if (wr_hi) stage_d[DW-1:GRP_W] = wdata[DW-1:GRP_W];
    if (wr_lo) stage_d[GRP_W-1:0]  = wdata[GRP_W-1:0];
    if (hw_standby) stage_d = '0;
    stage_en = hw_standby | (we & !sw_standby & (wr_hi | wr_lo));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        stage_q <= '0;
    else if (stage_en) stage_q <= stage_d;
  end

  always_comb begin
    rdata = '1;
    case (sel)
      SEL_BASE: rdata = mode_split ? {stage_q[DW-1:GRP_W], ONES_N} : stage_q;
      SEL_ALT:  rdata = mode_split ? {ONES_N, stage_q[GRP_W-1:0]} : '1;
      default:  rdata = '1;
    endcase
  end

  assign stage = stage_q;

  AST_HW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    hw_standby |=> (stage == '0)); // R9
  AST_SW_STAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_standby && !hw_standby) |=> $stable(stage)); // R10
  AST_RSVD_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_split && addr == ALT_A) |-> (rdata == '1)); // R3
endmodule

// File: rtl/pstage_xfer.sv
module pstage_xfer #(
  parameter int GRP_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sw_standby,
  input  logic               mode_split,
  input  logic               trig_hi,
  input  logic               trig_lo,
  input  logic               en_hi,
  input  logic               en_lo,
  input  logic [2*GRP_W-1:0] stage,
  output logic [2*GRP_W-1:0] port_q
);
  localparam int NGRP = 2;
  localparam int DW   = NGRP * GRP_W;

  logic [NGRP-1:0] grp_trig, grp_en, grp_ld;

  always_comb begin
    grp_trig[0] = trig_lo;
    grp_trig[1] = mode_split ? trig_hi : trig_lo;
    grp_en      = {en_hi, en_lo};
    grp_ld      = grp_trig & grp_en & {NGRP{!sw_standby}};
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic [GRP_W-1:0] nib_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         nib_q <= '0;
      else if (grp_ld[g]) nib_q <= stage[g*GRP_W +: GRP_W];
    end
    assign port_q[g*GRP_W +: GRP_W] = nib_q;
  end

  AST_LOAD_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (en_lo && trig_lo && !sw_standby) |=> (port_q[GRP_W-1:0] == $past(stage[GRP_W-1:0]))); // R5
  AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en_hi |=> $stable(port_q[DW-1:GRP_W])); // R7
  AST_SHARED_HI_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_split && !trig_lo) |=> $stable(port_q[DW-1:GRP_W])); // R6
  AST_SW_PORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    sw_standby |=> $stable(port_q)); // R10
endmodule

// File: rtl/pattern_stage.sv
module pattern_stage #(
  parameter int GRP_W    = 4,
  parameter int ADDR_W   = 3,
  parameter int BASE_OFF = 4,
  parameter int ALT_OFF  = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hw_standby,
  input  logic                 sw_standby,
  input  logic                 mode_split,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_we,
  input  logic [2*GRP_W-1:0]   bus_wdata,
  output logic [2*GRP_W-1:0]   bus_rdata,
  input  logic                 trig_hi,
  input  logic                 trig_lo,
  input  logic                 en_hi,
  input  logic                 en_lo,
  output logic [2*GRP_W-1:0]   port_q
);
  localparam int DW = 2 * GRP_W;
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE_OFF);
  localparam logic [ADDR_W-1:0] ALT_A  = ADDR_W'(ALT_OFF);

  logic [DW-1:0] stage;

  pstage_regfile #(
    .GRP_W(GRP_W), .ADDR_W(ADDR_W), .BASE_OFF(BASE_OFF), .ALT_OFF(ALT_OFF)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .hw_standby(hw_standby), .sw_standby(sw_standby),
    .mode_split(mode_split), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
    .stage(stage), .rdata(bus_rdata)
  );

  pstage_xfer #(.GRP_W(GRP_W)) u_xfer (
    .clk(clk), .rst_n(rst_n), .sw_standby(sw_standby), .mode_split(mode_split),
    .trig_hi(trig_hi), .trig_lo(trig_lo), .en_hi(en_hi), .en_lo(en_lo),
    .stage(stage), .port_q(port_q)
  );

  AST_OTHER_ADDR_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != BASE_A && bus_addr != ALT_A) |-> (bus_rdata == '1)); // R11
endmodule

// File: tb/sim_pattern_stage.sv
module sim_pattern_stage;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n, hw_standby, sw_standby, mode_split;
  logic [2:0] bus_addr;
  logic bus_we;
  logic [7:0] bus_wdata, bus_rdata, port_q;
  logic trig_hi, trig_lo, en_hi, en_lo;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pattern_stage u0 (
    .clk(clk), .rst_n(rst_n), .hw_standby(hw_standby), .sw_standby(sw_standby),
    .mode_split(mode_split), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .trig_hi(trig_hi),
    .trig_lo(trig_lo), .en_hi(en_hi), .en_lo(en_lo), .port_q(port_q)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_check(string req, logic [2:0] a, logic [7:0] exp);
    @(negedge clk);
    bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic pulse(logic hi, logic lo);
    @(negedge clk);
    trig_hi = hi; trig_lo = lo;
    @(negedge clk);
    trig_hi = 1'b0; trig_lo = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 port", port_q, 8'h00);
    rd_check("R1 stage", 3'd4, 8'h00);
  endtask

  task automatic t_shared_rw;
    mode_split = 1'b0;
    wr(3'd4, 8'hA5);
    rd_check("R2", 3'd4, 8'hA5);
    wr(3'd6, 8'h3C);
    rd_check("R3 read", 3'd6, 8'hFF);
    rd_check("R3 ignored", 3'd4, 8'hA5);
    wr(3'd2, 8'h11);
    rd_check("R11 read", 3'd2, 8'hFF);
    rd_check("R11 ignored", 3'd4, 8'hA5);
  endtask

  task automatic t_shared_trig;
    pulse(1'b1, 1'b0);
    check("R6 hi strobe ignored", port_q, 8'h00);
    pulse(1'b0, 1'b1);
    check("R6 lo strobe both", port_q, 8'hA5);
  endtask

  task automatic t_enable;
    wr(3'd4, 8'h5A);
    en_hi = 1'b0;
    pulse(1'b0, 1'b1);
    check("R7", port_q, 8'hAA);
    en_hi = 1'b1;
  endtask

  task automatic t_split;
    mode_split = 1'b1;
    rd_check("R4 hi view", 3'd4, 8'h5F);
    rd_check("R4 lo view", 3'd6, 8'hFA);
    wr(3'd4, 8'h3C);
    rd_check("R4 hi write", 3'd4, 8'h3F);
    rd_check("R4 lo kept", 3'd6, 8'hFA);
    wr(3'd6, 8'h96);
    rd_check("R4 lo write", 3'd6, 8'hF6);
    rd_check("R4 hi kept", 3'd4, 8'h3F);
    pulse(1'b1, 1'b0);
    check("R5 hi only", port_q, 8'h3A);
    pulse(1'b0, 1'b1);
    check("R5 lo only", port_q, 8'h36);
  endtask

  task automatic t_collide;
    mode_split = 1'b0;
    @(negedge clk);
    bus_addr = 3'd4; bus_wdata = 8'hC1; bus_we = 1'b1; trig_lo = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; trig_lo = 1'b0;
    check("R8 old value to port", port_q, 8'h36);
    rd_check("R8 write kept", 3'd4, 8'hC1);
    pulse(1'b0, 1'b1);
    check("R8 new value later", port_q, 8'hC1);
  endtask

  task automatic t_sw_standby;
    @(negedge clk);
    sw_standby = 1'b1;
    wr(3'd4, 8'h77);
    pulse(1'b0, 1'b1);
    @(negedge clk);
    sw_standby = 1'b0;
    check("R10 port held", port_q, 8'hC1);
    rd_check("R10 stage held", 3'd4, 8'hC1);
  endtask

  task automatic t_hw_standby;
    @(negedge clk);
    hw_standby = 1'b1;
    @(negedge clk);
    hw_standby = 1'b0;
    rd_check("R9 stage cleared", 3'd4, 8'h00);
    check("R9 port kept", port_q, 8'hC1);
  endtask

  initial begin
    rst_n = 1'b0; hw_standby = 1'b0; sw_standby = 1'b0; mode_split = 1'b0;
    bus_addr = 3'd0; bus_we = 1'b0; bus_wdata = 8'h00;
    trig_hi = 1'b0; trig_lo = 1'b0; en_hi = 1'b1; en_lo = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_shared_rw();
    t_shared_trig();
    t_enable();
    t_split();
    t_collide();
    t_sw_standby();
    t_hw_standby();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule